// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Manager

This block holds the write-protect state of every erase block in a flash array. Each block is in exactly one of three states: unlocked, locked, or lock-tight. Lock-tight is sticky. Program and erase logic elsewhere in the chip reads the state of any block through a registered lookup port, and refuses to act on a block that is not unlocked.

Software sets a first-block register and a last-block register, then issues one of four range commands: unlock a range, unlock every block, lock a range, or make a range lock-tight. The block then walks the selected blocks at one block per clock. As it goes, it updates the state array and a write-protect status register. When the walk ends it raises a one-cycle done pulse, reports a command-error flag, and sets an interrupt-pending flag that stays up until it is acknowledged.

Top module: `wp_lock_mgr`

## Requirements
- R1: After reset, every block reads locked (code 2) through the lookup port. The status register reads 2. The first/last registers read 0. busy, done, cmd_err and irq_pend are low.
- R2: A write to the first-block register keeps the low BLK_W bits of the data and loads that value into both the first and the last register. A write to the last-block register keeps the low BLK_W bits and changes only the last register.
- R3: Command 0x23 (unlock range) sets blocks first..last inclusive to unlocked (code 4), and command 0x2A (lock range) sets them to locked (code 2). Both handle one block per clock. For k blocks, done rises in the k-th cycle after the accepting edge.
- R4: An unlock-range, unlock-all or lock-range walk that meets a lock-tight block (code 1) stops there with done. That block and every later block keep their state.
- R5: Command 0x2C (lock-tight range) leaves unlocked blocks in the range as they are and sets every other block in the range to lock-tight. It never stops early.
- R6: Command 0x27 (unlock all) walks from block 0 to block NUM_BLOCKS-1 and follows the stopping rule of R4. It does not change the first/last registers.
- R7: A walk that reaches a block index at or above NUM_BLOCKS ends with done and cmd_err high. Blocks below that index are already updated. cmd_err clears when the next command is accepted.
- R8: Every state change also writes the new state code into the status register. A block that is skipped or left unchanged does not alter the status register.
- R9: irq_pend goes high together with done. It is cleared by irq_ack. If completion and irq_ack fall in the same cycle, irq_pend stays set.
- R10: A command that arrives while busy is high is refused. A code other than 0x23, 0x27, 0x2A or 0x2C is ignored: no walk starts and no done is raised.
- R11: lk_state gives the state of block lk_blk one cycle after it is presented. If a walk writes that block on the same edge, lk_state shows the state from before the write. lk_state is 0 for an index at or above NUM_BLOCKS.
- R12: done is high for exactly one cycle per accepted command and is never high while busy is high.
- R13: If the first register is greater than the last register, a range command ends with done after one cycle and changes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| first_we | input | 1 | Write strobe for the first-block register |
| last_we | input | 1 | Write strobe for the last-block register |
| blk_wdata | input | DATA_W | Data for the register writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| irq_ack | input | 1 | Clears interrupt-pending |
| lk_blk | input | BLK_W | Block index for the lookup port |
| lk_state | output | 3 | Registered state of lk_blk |
| first_blk | output | BLK_W | First-block register |
| last_blk | output | BLK_W | Last-block register |
| wp_status | output | 3 | State most recently written by a walk |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | The last walk ran past the block count |
| irq_pend | output | 1 | Interrupt pending |

## Verification
The walker writing a block and the lookup port reading that same block can land on one clock edge. The bench provokes this by holding lk_blk on the middle block of a short unlock walk. It expects the old code in the cycle the write lands and the new code one cycle later. A second collision, between completion and irq_ack, is provoked by holding irq_ack through the end of a walk. It is judged by irq_pend staying set in the done cycle and falling in the cycle after. In both cases a behavioural model compares every output on every clock.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
  localparam logic [2:0] ST_TIGHT    = 3'b001;
  localparam logic [2:0] ST_LOCKED   = 3'b010;
  localparam logic [2:0] ST_UNLOCKED = 3'b100;

  localparam logic [7:0] OPC_UNLOCK     = 8'h23;
  localparam logic [7:0] OPC_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OPC_LOCK       = 8'h2A;
  localparam logic [7:0] OPC_TIGHT      = 8'h2C;

  typedef enum logic [1:0] {
    WALK_UNLOCK = 2'd0,
    WALK_LOCK   = 2'd1,
    WALK_TIGHT  = 2'd2
  } walk_op_e;

  function automatic logic opc_known(input logic [7:0] c);
    return (c == OPC_UNLOCK) || (c == OPC_UNLOCK_ALL) ||
           (c == OPC_LOCK) || (c == OPC_TIGHT);
  endfunction

  function automatic logic [2:0] op_target(input walk_op_e op);
    case (op)
      WALK_UNLOCK: return ST_UNLOCKED;
      WALK_LOCK:   return ST_LOCKED;
      default:     return ST_TIGHT;
    endcase
  endfunction
endpackage

// File: rtl/wpl_regs.sv
module wpl_regs #(
  parameter int NUM_BLOCKS = 48,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_we,
  input  logic             last_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [BLK_W-1:0] first_q,
  output logic [BLK_W-1:0] last_q
);
  logic [BLK_W-1:0] masked;
  assign masked = wdata[BLK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (first_we) begin
        first_q <= masked;
        last_q  <= masked;
      end
      if (last_we) last_q <= masked;
    end
  end

  AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (first_we && !last_we) |=> (last_q == first_q)); // R2
endmodule

// File: rtl/wpl_array.sv
module wpl_array import wpl_pkg::*; #(
  parameter int NUM_BLOCKS = 48,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic [2:0]       wdata,
  input  logic [BLK_W-1:0] raddr,
  output logic [2:0]       rdata,
  input  logic [BLK_W-1:0] lk_addr,
  output logic [2:0]       lk_state
);
  logic [2:0] cell_vec [NUM_BLOCKS];

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
    logic [2:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= ST_LOCKED;
      else if (we && (waddr == BLK_W'(i))) q <= wdata;
    end
    assign cell_vec[i] = q;
  end

  logic [2:0] lk_next;
  logic [2:0] wcur;

  always_comb begin
    rdata   = '0;
    lk_next = '0;
    wcur    = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (raddr == BLK_W'(i))   rdata   = cell_vec[i];
      if (lk_addr == BLK_W'(i)) lk_next = cell_vec[i];
      if (waddr == BLK_W'(i))   wcur    = cell_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lk_state <= '0;
    else     lk_state <= lk_next;
  end

  AST_TIGHT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (we && wcur == ST_TIGHT) |-> (wdata == ST_TIGHT)); // R4
  AST_ONEHOT_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |-> ($countones(wdata) == 1)); // R8
  AST_LK_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(lk_addr) >= NUM_BLOCKS) |=> (lk_state == 3'b000)); // R11
endmodule

// File: rtl/wpl_walker.sv
module wpl_walker import wpl_pkg::*; #(
  parameter int NUM_BLOCKS = 48,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             irq_ack,
  input  logic [BLK_W-1:0] first_q,
  input  logic [BLK_W-1:0] last_q,
  input  logic [2:0]       cur_state,
  output logic [BLK_W-1:0] idx,
  output logic             we,
  output logic [2:0]       wdata,
  output logic [2:0]       wp_status,
  output logic             busy,
  output logic             done,
  output logic             cmd_err,
  output logic             irq_pend
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  walk_op_e         op_q;
  logic [BLK_W-1:0] wend_q;
  logic             accept, fin, err_hit, step;

  assign accept = !busy && cmd_valid && opc_known(cmd_code);
  assign wdata  = op_target(op_q);

  always_comb begin
    we = 1'b0; fin = 1'b0; err_hit = 1'b0; step = 1'b0;
    if (busy) begin
      if (idx > wend_q) begin
        fin = 1'b1;
      end else if (32'(idx) >= NUM_BLOCKS) begin
        fin = 1'b1;
        err_hit = 1'b1;
      end else if (op_q == WALK_TIGHT) begin
        we   = (cur_state != ST_UNLOCKED);
        fin  = (idx == wend_q);
        step = !fin;
      end else if (cur_state == ST_TIGHT) begin
        fin = 1'b1;
      end else begin
        we   = 1'b1;
        fin  = (idx == wend_q);
        step = !fin;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      irq_pend  <= 1'b0;
      idx       <= '0;
      wend_q    <= '0;
      op_q      <= WALK_UNLOCK;
      wp_status <= ST_LOCKED;
    end else begin
      done <= fin;
      if (accept) begin
        busy    <= 1'b1;
        cmd_err <= 1'b0;
        if (cmd_code == OPC_UNLOCK_ALL) begin
          idx    <= '0;
          wend_q <= LAST_BLK;
        end else begin
          idx    <= first_q;
          wend_q <= last_q;
        end
        case (cmd_code)
          OPC_LOCK:  op_q <= WALK_LOCK;
          OPC_TIGHT: op_q <= WALK_TIGHT;
          default:   op_q <= WALK_UNLOCK;
        endcase
      end
      if (fin) begin
        busy    <= 1'b0;
        cmd_err <= err_hit;
      end
      if (step) idx <= idx + 1'b1;
      if (we) wp_status <= wdata;
      if (fin) irq_pend <= 1'b1;
      else if (irq_ack) irq_pend <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R12
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> irq_pend); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> done); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(wend_q))); // R10
  AST_ONE_PER_CLK: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (idx == $past(idx) || idx == $past(idx) + 1'b1)); // R3
endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr #(
  parameter int NUM_BLOCKS = 48,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_we,
  input  logic              last_we,
  input  logic [DATA_W-1:0] blk_wdata,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              irq_ack,
  input  logic [BLK_W-1:0]  lk_blk,
  output logic [2:0]        lk_state,
  output logic [BLK_W-1:0]  first_blk,
  output logic [BLK_W-1:0]  last_blk,
  output logic [2:0]        wp_status,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              irq_pend
);
  logic [BLK_W-1:0] idx;
  logic             we;
  logic [2:0]       wdata, cur_state;

  wpl_regs #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .first_we(first_we), .last_we(last_we),
    .wdata(blk_wdata), .first_q(first_blk), .last_q(last_blk)
  );

  wpl_walker #(.NUM_BLOCKS(NUM_BLOCKS)) u_walk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .irq_ack(irq_ack), .first_q(first_blk), .last_q(last_blk),
    .cur_state(cur_state), .idx(idx), .we(we), .wdata(wdata),
    .wp_status(wp_status), .busy(busy), .done(done), .cmd_err(cmd_err),
    .irq_pend(irq_pend)
  );

  wpl_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_arr (
    .clk(clk), .rst(rst), .we(we), .waddr(idx), .wdata(wdata),
    .raddr(idx), .rdata(cur_state), .lk_addr(lk_blk), .lk_state(lk_state)
  );
endmodule

// File: tb/sim_wp_lock_mgr.sv
`timescale 1ns/1ps
module sim_wp_lock_mgr;
  localparam int NUM = 48;
  localparam int BW  = 6;

  logic clk = 0, rst = 1;
  logic first_we = 0, last_we = 0, cmd_valid = 0, irq_ack = 0;
  logic [15:0] blk_wdata = 0;
  logic [7:0]  cmd_code = 0;
  logic [BW-1:0] lk_blk = 0;
  logic [2:0] lk_state, wp_status;
  logic [BW-1:0] first_blk, last_blk;
  logic busy, done, cmd_err, irq_pend;

  int total = 0, bad = 0, cyc = 0;
  bit chk_en = 0, finished = 0;

  always #2 clk = ~clk;

  wp_lock_mgr #(.NUM_BLOCKS(NUM), .DATA_W(16)) u0 (
    .clk(clk), .rst(rst), .first_we(first_we), .last_we(last_we),
    .blk_wdata(blk_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .irq_ack(irq_ack), .lk_blk(lk_blk), .lk_state(lk_state),
    .first_blk(first_blk), .last_blk(last_blk), .wp_status(wp_status),
    .busy(busy), .done(done), .cmd_err(cmd_err), .irq_pend(irq_pend)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int st [NUM];
  int m_f, m_l, m_busy, m_idx, m_end, m_op, m_done, m_err, m_irq, m_wp, m_lk;

  always @(posedge clk) begin
    int lk_n, fin, ehit, tgt, code;
    if (rst) begin
      foreach (st[i]) st[i] = 2;
      m_f = 0; m_l = 0; m_busy = 0; m_idx = 0; m_end = 0; m_op = 0;
      m_done = 0; m_err = 0; m_irq = 0; m_wp = 2; m_lk = 0;
    end else begin
      lk_n = (int'(lk_blk) < NUM) ? st[lk_blk] : 0;
      fin = 0; ehit = 0; code = int'(cmd_code);
      if (m_busy != 0) begin
        tgt = (m_op == 0) ? 4 : (m_op == 1) ? 2 : 1;
        if (m_idx > m_end) fin = 1;
        else if (m_idx >= NUM) begin fin = 1; ehit = 1; end
        else if (m_op == 2) begin
          if (st[m_idx] != 4) begin st[m_idx] = 1; m_wp = 1; end
          if (m_idx == m_end) fin = 1; else m_idx++;
        end else if (st[m_idx] == 1) fin = 1;
        else begin
          st[m_idx] = tgt; m_wp = tgt;
          if (m_idx == m_end) fin = 1; else m_idx++;
        end
      end else if (cmd_valid && (code == 'h23 || code == 'h27 || code == 'h2A || code == 'h2C)) begin
        m_busy = 1; m_err = 0;
        m_op  = (code == 'h2A) ? 1 : (code == 'h2C) ? 2 : 0;
        m_idx = (code == 'h27) ? 0 : m_f;
        m_end = (code == 'h27) ? NUM - 1 : m_l;
      end
      m_done = fin;
      if (fin != 0) begin m_busy = 0; m_err = ehit; m_irq = 1; end
      else if (irq_ack) m_irq = 0;
      if (first_we) begin m_f = blk_wdata % (1 << BW); m_l = m_f; end
      if (last_we) m_l = blk_wdata % (1 << BW);
      m_lk = lk_n;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (chk_en) begin
      chk("R11 lk_state", int'(lk_state), m_lk);
      chk("R8 wp_status", int'(wp_status), m_wp);
      chk("R2 first_blk", int'(first_blk), m_f);
      chk("R2 last_blk", int'(last_blk), m_l);
      chk("R10 busy", int'(busy), m_busy);
      chk("R12 done", int'(done), m_done);
      chk("R7 cmd_err", int'(cmd_err), m_err);
      chk("R9 irq_pend", int'(irq_pend), m_irq);
    end
    if (cyc > 20000 && !finished) begin
      bad++; total++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_first(int v);
    first_we = 1; blk_wdata = 16'(v); @(negedge clk); first_we = 0;
  endtask
  task automatic wr_last(int v);
    last_we = 1; blk_wdata = 16'(v); @(negedge clk); last_we = 0;
  endtask
  task automatic issue(int c);
    cmd_valid = 1; cmd_code = 8'(c); @(negedge clk); cmd_valid = 0;
  endtask
  task automatic wait_done(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 300);
  endtask
  task automatic peek(int b, output int v);
    lk_blk = BW'(b); @(negedge clk); v = int'(lk_state);
  endtask

  initial begin
    int n, v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_en = 1;
    chk("R1 busy", int'(busy), 0); chk("R1 done", int'(done), 0);
    chk("R1 err", int'(cmd_err), 0); chk("R1 irq", int'(irq_pend), 0);
    chk("R1 wp", int'(wp_status), 2); chk("R1 first", int'(first_blk), 0);
    peek(0, v);  chk("R1 blk0", v, 2);
    peek(47, v); chk("R1 blk47", v, 2);
    peek(50, v); chk("R11 out of range", v, 0);

    wr_first('h0105);
    chk("R2 first masked", int'(first_blk), 5); chk("R2 last copied", int'(last_blk), 5);
    wr_last('hFF09);
    chk("R2 last masked", int'(last_blk), 9); chk("R2 first kept", int'(first_blk), 5);

    issue('h23); wait_done(n);
    chk("R3 unlock cycles", n, 5);
    chk("R8 wp unlock", int'(wp_status), 4);
    chk("R9 irq set", int'(irq_pend), 1);
    @(negedge clk); chk("R12 done low", int'(done), 0);
    peek(5, v); chk("R3 blk5", v, 4);
    peek(9, v); chk("R3 blk9", v, 4);
    peek(10, v); chk("R3 blk10", v, 2);
    peek(4, v); chk("R3 blk4", v, 2);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R9 irq ack", int'(irq_pend), 0);

    wr_first(3); wr_last(12); issue('h2C); wait_done(n);
    chk("R5 tight cycles", n, 10);
    peek(3, v); chk("R5 blk3", v, 1);
    peek(7, v); chk("R5 skip unlocked", v, 4);
    peek(12, v); chk("R5 blk12", v, 1);
    peek(13, v); chk("R5 blk13", v, 2);

    issue('h27); wait_done(n);
    chk("R6 stop cycles", n, 4);
    chk("R6 regs kept", int'(first_blk), 3);
    peek(2, v); chk("R6 blk2", v, 4);
    peek(13, v); chk("R6 past tight", v, 2);

    wr_first(0); wr_last(15); issue('h2A); wait_done(n);
    chk("R4 stop cycles", n, 4);
    chk("R8 wp lock", int'(wp_status), 2);
    peek(1, v); chk("R4 blk1", v, 2);
    peek(3, v); chk("R4 tight kept", v, 1);
    peek(7, v); chk("R4 past tight", v, 4);

    wr_first(40); wr_last(60); issue('h23); wait_done(n);
    chk("R7 err cycles", n, 9);
    chk("R7 err set", int'(cmd_err), 1);
    peek(47, v); chk("R7 blk47", v, 4);

    wr_first(20); wr_last(18); issue('h23); wait_done(n);
    chk("R13 empty cycles", n, 1);
    chk("R7 err cleared", int'(cmd_err), 0);
    peek(20, v); chk("R13 blk20", v, 2);

    wr_first(30); wr_last(35); issue('h23); issue('h2A); wait_done(n);
    chk("R10 refused cycles", n, 5);
    peek(30, v); chk("R10 blk30", v, 4);
    issue('h55);
    chk("R10 unknown", int'(busy), 0);
    @(negedge clk); chk("R10 no done", int'(done), 0);

    irq_ack = 1; @(negedge clk); irq_ack = 0;
    wr_first(36); wr_last(37); issue('h23);
    irq_ack = 1;
    wait_done(n);
    chk("R9 set wins", int'(irq_pend), 1);
    @(negedge clk); chk("R9 ack after", int'(irq_pend), 0);
    irq_ack = 0;

    wr_first(24); wr_last(26); lk_blk = 25; @(negedge clk);
    issue('h23);
    @(negedge clk); chk("R11 before", int'(lk_state), 2);
    @(negedge clk); chk("R11 same edge old", int'(lk_state), 2);
    @(negedge clk); chk("R11 after write", int'(lk_state), 4);
    chk("R3 short done", int'(done), 1);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule